// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits between a set of interrupt sources and a small processor core. It keeps one flag bit per source and gates each flag with the source's own enable and with two global enable bits. It presents the core with a registered request line and a vector address. The sources fall into two groups. The core group holds the edge-triggered external pins and the other core events. The peripheral group holds the event pulses from peripherals. Flags are set by events whatever the enables say. Software clears them with write-one-to-clear pulses.

A mode input selects between two schemes. In single-level mode every source uses the vector 0x000008. The first global enable acts as the master enable. The second global enable only gates the peripheral group. In two-priority mode each source has a priority bit, and high priority is the reset value. The first global enable becomes the high-level enable and the second becomes the low-level enable. High-priority requests use vector 0x000008. Low-priority requests use 0x000018 and need both global enables.

The core takes a request with a one-cycle accept pulse and ends the service routine with a one-cycle return pulse. A service-state machine tracks what is in service. Its states are `ST_IDLE`, `ST_LO` (low level in service), `ST_HI` (high level or single-level mode in service) and `ST_NEST` (high level preempting a low one). Its transitions are:
- `ST_IDLE`→`ST_HI` on accepting a high or single-level request.
- `ST_IDLE`→`ST_LO` on accepting a low request.
- `ST_LO`→`ST_NEST` on accepting a high request.
- `ST_HI`→`ST_IDLE` on return, which sets the high enable.
- `ST_NEST`→`ST_LO` on return, which sets the high enable.
- `ST_LO`→`ST_IDLE` on return, which sets the low enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all flags are 0, `irq` is 0, both global enables are 0, every priority bit reads 1 (high), and `irq_vec` is 0x000008.
- R2: An external pin passes a two-flop synchronizer. Its flag sets on a rising edge when its `pin_rise` bit is 1 and on a falling edge when that bit is 0, never on the other edge.
- R3: A flag sets on its event regardless of enables and stays set until its `flag_clr` bit is pulsed. An event in the same cycle as a clear leaves the flag set. A flag that is still set requests again once the enables allow it.
- R4: With `prio_mode`=0, a core-group source (indices below `PIN_N+CORE_EVT_N`) raises `irq` with vector 0x000008 exactly when its flag, its enable and `glb_hi` are all 1.
- R5: With `prio_mode`=0, a peripheral-group source also needs `glb_lo`=1 to raise `irq`.
- R6: With `prio_mode`=1, a source whose priority bit is 1 raises `irq` with vector 0x000008 exactly when its flag, its enable and `glb_hi` are 1, whatever `glb_lo` is.
- R7: With `prio_mode`=1, a source whose priority bit is 0 raises `irq` with vector 0x000018 exactly when its flag, its enable, `glb_hi` and `glb_lo` are all 1.
- R8: When high-level and low-level requests first become pending in the same cycle, the vector is 0x000008.
- R9: An accept (`core_ack` while `irq`=1) drops `irq` on the next cycle. It clears `glb_lo` if the accepted vector was the low one, and `glb_hi` otherwise. Accept and return take precedence over a software write of the global enables.
- R10: While a low-level request is in service, a high-level request still raises `irq` and can be accepted (nesting). The low level cannot request again until its enable is restored.
- R11: A return restores the enable of the most recently accepted level still in service: `glb_hi` from a high or nested service, and `glb_lo` from a low service.
- R12: While `irq` stays 1, `irq_vec` does not change, even if a request of another level appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_mode | input | 1 | 0 single-level scheme, 1 two-priority scheme |
| pin_in | input | PIN_N | Asynchronous external interrupt pins |
| pin_rise | input | PIN_N | Per pin: 1 rising edge, 0 falling edge |
| core_evt | input | CORE_EVT_N | Event pulses of the other core-group sources |
| peri_evt | input | PERI_N | Event pulses of the peripheral-group sources |
| flag_clr | input | SRC_N | Write-one-to-clear pulses per flag |
| src_en | input | SRC_N | Per-source enable |
| prio_we | input | 1 | Write strobe for the priority bits |
| prio_d | input | SRC_N | Priority data, 1 = high |
| glb_we | input | 1 | Write strobe for both global enables |
| glb_hi_d | input | 1 | Data for the high/master global enable |
| glb_lo_d | input | 1 | Data for the low/peripheral global enable |
| core_ack | input | 1 | Core accepts the pending request |
| core_ret | input | 1 | Core returns from the service routine |
| irq | output | 1 | Registered interrupt request |
| irq_vec | output | VEC_W | Vector address, held while `irq` is 1 |
| flags | output | SRC_N | Per-source flags (source order: pins, core events, peripherals) |
| glb_hi | output | 1 | High/master global enable |
| glb_lo | output | 1 | Low/peripheral global enable |
| prio_q | output | SRC_N | Current priority bits |

## Verification
The bench sweeps every source through every combination of its own enable, both global enables and, in two-priority mode, its priority bit. It checks `irq` and the vector each time. A controller that ignored group membership or the low enable would assert `irq` for a peripheral or low source that should stay silent. Each pin is tried with both edge selections and both transitions, which catches an inverted edge select or detection on both edges. A scripted nesting sequence runs in two-priority mode. A low request is latched, then a high one arrives, then both are accepted and both return. This exposes a vector that changes under a pending request, an accept that clears the wrong enable, and a return that restores the wrong level. Any of these leaves the wrong enable cleared after the returns, or lets the low source re-enter.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_NEST = 2'd3
    } svc_t;
endpackage

// File: rtl/icx_pin_edge.sv
module icx_pin_edge #(
    parameter int PIN_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_N-1:0] pin_in,
    input  logic [PIN_N-1:0] pin_rise,
    output logic [PIN_N-1:0] evt
);
    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        logic s1_q, s2_q, prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin_in[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign evt[i] = pin_rise[i] ? (s2_q & ~prev_q) : (~s2_q & prev_q);

        // R2: a single pin transition yields a one-cycle event only
        p_evt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> !evt[i]);
    end
endmodule

// File: rtl/icx_flags.sv
module icx_flags #(
    parameter int SRC_N = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] set_evt,
    input  logic [SRC_N-1:0] clr,
    output logic [SRC_N-1:0] flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | set_evt;
    end

    for (genvar i = 0; i < SRC_N; i++) begin : g_chk
        // R3: a flag persists until cleared
        p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i]) |=> flag_q[i]);
        // R3: an event sets the flag even when a clear coincides
        p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/icx_gate.sv
module icx_gate #(
    parameter int SRC_N  = 5,
    parameter int CORE_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic [SRC_N-1:0] flag,
    input  logic [SRC_N-1:0] en,
    input  logic [SRC_N-1:0] prio,
    input  logic             ghi,
    input  logic             glo,
    output logic             req_hi,
    output logic             req_lo
);
    logic [SRC_N-1:0] hit_one;
    logic [SRC_N-1:0] hit_hi;
    logic [SRC_N-1:0] hit_lo;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        logic live;
        assign live = flag[i] & en[i] & ghi;
        if (i < CORE_N) begin : g_core
            assign hit_one[i] = live;
        end else begin : g_peri
            assign hit_one[i] = live & glo;
        end
        assign hit_hi[i] = live & prio[i];
        assign hit_lo[i] = live & ~prio[i] & glo;
    end

    assign req_hi = mode ? |hit_hi : |hit_one;
    assign req_lo = mode & |hit_lo;

    // R7: a low-level request exists only in two-priority mode with both enables set
    p_lo_gating_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_lo |-> (mode && ghi && glo));
    // R4: nothing requests while the high/master enable is clear
    p_master_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ghi |-> (!req_hi && !req_lo));
endmodule

// File: rtl/icx_seq.sv
module icx_seq
    import pic_pkg::*;
#(
    parameter int               VEC_W  = 21,
    parameter logic [VEC_W-1:0] VEC_HI = 'h8,
    parameter logic [VEC_W-1:0] VEC_LO = 'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_hi,
    input  logic             req_lo,
    input  logic             core_ack,
    input  logic             core_ret,
    input  logic             glb_we,
    input  logic             glb_hi_d,
    input  logic             glb_lo_d,
    output logic             irq_q,
    output logic [VEC_W-1:0] vec_q,
    output logic             ghi_q,
    output logic             glo_q
);
    svc_t state, nxt;
    logic lvl_lo_q;
    logic ack_ok;
    logic ghi_d, glo_d;
    logic any_req;

    assign ack_ok  = core_ack & irq_q;
    assign any_req = req_hi | req_lo;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (ack_ok) nxt = lvl_lo_q ? ST_LO : ST_HI;
            ST_LO: begin
                if (ack_ok && !lvl_lo_q) nxt = ST_NEST;
                else if (!ack_ok && core_ret) nxt = ST_IDLE;
            end
            ST_HI:   if (!ack_ok && core_ret) nxt = ST_IDLE;
            ST_NEST: if (!ack_ok && core_ret) nxt = ST_LO;
        endcase
    end

    // global enable update: software write, then accept/return override
    always_comb begin
        ghi_d = glb_we ? glb_hi_d : ghi_q;
        glo_d = glb_we ? glb_lo_d : glo_q;
        if (ack_ok) begin
            if (lvl_lo_q) glo_d = 1'b0;
            else          ghi_d = 1'b0;
        end else if (core_ret) begin
            unique case (state)
                ST_HI, ST_NEST: ghi_d = 1'b1;
                ST_LO:          glo_d = 1'b1;
                ST_IDLE:        ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghi_q    <= 1'b0;
            glo_q    <= 1'b0;
            irq_q    <= 1'b0;
            vec_q    <= VEC_HI;
            lvl_lo_q <= 1'b0;
        end else begin
            ghi_q <= ghi_d;
            glo_q <= glo_d;
            irq_q <= any_req & ~ack_ok;
            if (!irq_q && any_req) begin
                vec_q    <= req_hi ? VEC_HI : VEC_LO;
                lvl_lo_q <= ~req_hi;
            end
        end
    end

    // R9: accept drops the request on the next cycle
    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> !irq_q);
    // R9: accepting a low vector clears only the low enable
    p_lo_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && lvl_lo_q && !glb_we) |=> (!glo_q && $stable(ghi_q)));
    // R12: the vector holds while the request stays up
    p_vec_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack_ok) |=> (!irq_q || $stable(vec_q)));
    // R8: a fresh request carries the high vector whenever a high request exists
    p_hi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && any_req) |=> (vec_q == ($past(req_hi) ? VEC_HI : VEC_LO)));
    // R11: return from a nested service goes back to low service with high enable set
    p_nest_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEST && core_ret && !ack_ok && !glb_we) |=> (ghi_q && state == ST_LO));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int               PIN_N      = 2,
    parameter int               CORE_EVT_N = 1,
    parameter int               PERI_N     = 2,
    parameter int               VEC_W      = 21,
    parameter logic [VEC_W-1:0] HI_VEC     = 'h8,
    parameter logic [VEC_W-1:0] LO_STEP    = 'h10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                prio_mode,
    input  logic [PIN_N-1:0]                    pin_in,
    input  logic [PIN_N-1:0]                    pin_rise,
    input  logic [CORE_EVT_N-1:0]               core_evt,
    input  logic [PERI_N-1:0]                   peri_evt,
    input  logic [PIN_N+CORE_EVT_N+PERI_N-1:0]  flag_clr,
    input  logic [PIN_N+CORE_EVT_N+PERI_N-1:0]  src_en,
    input  logic                                prio_we,
    input  logic [PIN_N+CORE_EVT_N+PERI_N-1:0]  prio_d,
    input  logic                                glb_we,
    input  logic                                glb_hi_d,
    input  logic                                glb_lo_d,
    input  logic                                core_ack,
    input  logic                                core_ret,
    output logic                                irq,
    output logic [VEC_W-1:0]                    irq_vec,
    output logic [PIN_N+CORE_EVT_N+PERI_N-1:0]  flags,
    output logic                                glb_hi,
    output logic                                glb_lo,
    output logic [PIN_N+CORE_EVT_N+PERI_N-1:0]  prio_q
);
    localparam int               CORE_N = PIN_N + CORE_EVT_N;
    localparam int               SRC_N  = CORE_N + PERI_N;
    localparam logic [VEC_W-1:0] LO_VEC = HI_VEC + LO_STEP;

    logic [PIN_N-1:0] pin_evt;
    logic [SRC_N-1:0] set_evt;
    logic             req_hi, req_lo;

    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= '1;
        else if (prio_we) prio_q <= prio_d;
    end

    icx_pin_edge #(.PIN_N(PIN_N)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_rise (pin_rise),
        .evt      (pin_evt)
    );

    assign set_evt = {peri_evt, core_evt, pin_evt};

    icx_flags #(.SRC_N(SRC_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr     (flag_clr),
        .flag_q  (flags)
    );

    icx_gate #(.SRC_N(SRC_N), .CORE_N(CORE_N)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (prio_mode),
        .flag   (flags),
        .en     (src_en),
        .prio   (prio_q),
        .ghi    (glb_hi),
        .glo    (glb_lo),
        .req_hi (req_hi),
        .req_lo (req_lo)
    );

    icx_seq #(.VEC_W(VEC_W), .VEC_HI(HI_VEC), .VEC_LO(LO_VEC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_hi   (req_hi),
        .req_lo   (req_lo),
        .core_ack (core_ack),
        .core_ret (core_ret),
        .glb_we   (glb_we),
        .glb_hi_d (glb_hi_d),
        .glb_lo_d (glb_lo_d),
        .irq_q    (irq),
        .vec_q    (irq_vec),
        .ghi_q    (glb_hi),
        .glo_q    (glb_lo)
    );

    // R6: in two-priority mode the vector is only ever one of the two addresses
    p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec == HI_VEC || irq_vec == LO_VEC));
    // R4: single-level mode never presents the low vector with a fresh request
    p_single_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_mode && !irq && (req_hi || req_lo)) |=> (irq_vec == HI_VEC));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/100ps
module tb_prio_irq_ctrl;
    localparam int NP = 2, NC = 1, NQ = 2, N = 5, VW = 21, NCORE = 3;
    localparam logic [31:0] V_HI = 32'h8, V_LO = 32'h18;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, prio_mode, prio_we, glb_we, glb_hi_d, glb_lo_d, core_ack, core_ret;
    logic [NP-1:0] pin_in, pin_rise;
    logic [NC-1:0] core_evt;
    logic [NQ-1:0] peri_evt;
    logic [N-1:0]  flag_clr, src_en, prio_d, flags, prio_q;
    logic          irq, glb_hi, glb_lo;
    logic [VW-1:0] irq_vec;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .pin_in(pin_in), .pin_rise(pin_rise),
        .core_evt(core_evt), .peri_evt(peri_evt), .flag_clr(flag_clr), .src_en(src_en),
        .prio_we(prio_we), .prio_d(prio_d), .glb_we(glb_we), .glb_hi_d(glb_hi_d),
        .glb_lo_d(glb_lo_d), .core_ack(core_ack), .core_ret(core_ret), .irq(irq),
        .irq_vec(irq_vec), .flags(flags), .glb_hi(glb_hi), .glb_lo(glb_lo), .prio_q(prio_q)
    );

    int total = 0, bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_glb(input logic h, input logic l);
        glb_we = 1'b1; glb_hi_d = h; glb_lo_d = l;
        step(1);
        glb_we = 1'b0;
    endtask

    task automatic set_prio(input logic [N-1:0] v);
        prio_we = 1'b1; prio_d = v;
        step(1);
        prio_we = 1'b0;
    endtask

    task automatic clr_flags(input logic [N-1:0] m);
        flag_clr = m;
        step(1);
        flag_clr = '0;
        step(2);
    endtask

    task automatic raise(input int s);
        if (s < NP) begin
            pin_rise[s] = 1'b1;
            pin_in[s] = 1'b1;
            step(6);
            pin_in[s] = 1'b0;
            step(6);
        end else if (s < NCORE) begin
            core_evt[s-NP] = 1'b1;
            step(1);
            core_evt = '0;
        end else begin
            peri_evt[s-NCORE] = 1'b1;
            step(1);
            peri_evt = '0;
        end
        step(3);
    endtask

    task automatic pulse_ack();
        core_ack = 1'b1; step(1); core_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        core_ret = 1'b1; step(1); core_ret = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; prio_mode = 1'b0; prio_we = 1'b0; glb_we = 1'b0;
        glb_hi_d = 1'b0; glb_lo_d = 1'b0; core_ack = 1'b0; core_ret = 1'b0;
        pin_in = '0; pin_rise = '1; core_evt = '0; peri_evt = '0;
        flag_clr = '0; src_en = '0; prio_d = '0;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 flags", flags, 0);
        chk("R1 glb_hi", glb_hi, 0);
        chk("R1 glb_lo", glb_lo, 0);
        chk("R1 prio", prio_q, 5'b11111);
        chk("R1 vec", irq_vec, V_HI);

        // R2 edge selection on each pin
        for (int p = 0; p < NP; p++) begin
            for (int r = 0; r < 2; r++) begin
                pin_rise[p] = r[0];
                step(2);
                pin_in[p] = 1'b1;
                step(6);
                chk($sformatf("R2 pin%0d sel%0d rising", p, r), flags[p], r[0]);
                clr_flags('1);
                pin_in[p] = 1'b0;
                step(6);
                chk($sformatf("R2 pin%0d sel%0d falling", p, r), flags[p], !r[0]);
                clr_flags('1);
            end
        end
        pin_rise = '1;

        // R3 flag behaviour with enables off
        core_evt = 1'b1; step(1); core_evt = '0; step(5);
        chk("R3 flag sets while disabled", flags[2], 1);
        chk("R3 no irq while disabled", irq, 0);
        core_evt = 1'b1; flag_clr = 5'b00100; step(1);
        core_evt = '0; flag_clr = '0; step(1);
        chk("R3 set beats clear", flags[2], 1);
        clr_flags(5'b00100);
        chk("R3 cleared", flags[2], 0);

        // R4/R5 single-level sweep
        prio_mode = 1'b0;
        for (int s = 0; s < N; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic h, l, e, exp_irq;
                h = c[0]; l = c[1]; e = c[2];
                exp_irq = e & h & ((s < NCORE) ? 1'b1 : l);
                src_en = '0; src_en[s] = e;
                set_glb(h, l);
                clr_flags('1);
                raise(s);
                chk($sformatf("%s src%0d cfg%0d irq", (s < NCORE) ? "R4" : "R5", s, c), irq, exp_irq);
                if (exp_irq) chk($sformatf("R4 src%0d vec", s), irq_vec, V_HI);
                clr_flags('1);
            end
        end

        // R6/R7 two-priority sweep
        prio_mode = 1'b1;
        for (int s = 0; s < N; s++) begin
            for (int c = 0; c < 16; c++) begin
                logic h, l, e, p, exp_irq;
                logic [N-1:0] pv;
                h = c[0]; l = c[1]; e = c[2]; p = c[3];
                exp_irq = e & h & (p | l);
                pv = '1; pv[s] = p;
                set_prio(pv);
                src_en = '0; src_en[s] = e;
                set_glb(h, l);
                clr_flags('1);
                raise(s);
                chk($sformatf("%s src%0d cfg%0d irq", p ? "R6" : "R7", s, c), irq, exp_irq);
                if (exp_irq) chk($sformatf("%s src%0d vec", p ? "R6" : "R7", s), irq_vec, p ? V_HI : V_LO);
                clr_flags('1);
            end
        end

        // R8 simultaneous high (src2) and low (src3)
        set_prio(5'b10111);
        src_en = '1;
        set_glb(1, 1);
        clr_flags('1);
        core_evt = 1'b1; peri_evt = 2'b01; step(1);
        core_evt = '0; peri_evt = '0; step(2);
        chk("R8 irq", irq, 1);
        chk("R8 high vector wins", irq_vec, V_HI);
        clr_flags('1);

        // R12 / R9 / R10 / R11 nesting sequence
        raise(3);
        chk("R7 low pending", irq, 1);
        chk("R7 low vector", irq_vec, V_LO);
        raise(2);
        chk("R12 irq held", irq, 1);
        chk("R12 vector held", irq_vec, V_LO);
        pulse_ack();
        chk("R9 irq drops after accept", irq, 0);
        chk("R9 low accept clears glb_lo", glb_lo, 0);
        chk("R9 low accept keeps glb_hi", glb_hi, 1);
        step(1);
        chk("R10 high preempts", irq, 1);
        chk("R10 preempt vector", irq_vec, V_HI);
        pulse_ack();
        chk("R9 high accept clears glb_hi", glb_hi, 0);
        chk("R9 irq drops nested", irq, 0);
        step(3);
        chk("R10 low blocked while nested", irq, 0);
        clr_flags(5'b00100);
        pulse_ret();
        chk("R11 nested return sets glb_hi", glb_hi, 1);
        chk("R11 nested return keeps glb_lo", glb_lo, 0);
        step(2);
        chk("R10 low cannot re-enter", irq, 0);
        clr_flags(5'b01000);
        pulse_ret();
        chk("R11 low return sets glb_lo", glb_lo, 1);
        step(2);
        chk("R11 idle after returns", irq, 0);

        // R9 single-level accept and R3 re-request
        prio_mode = 1'b0;
        set_glb(1, 1);
        clr_flags('1);
        raise(2);
        chk("R4 request", irq, 1);
        glb_we = 1'b1; glb_hi_d = 1'b1; glb_lo_d = 1'b1;
        pulse_ack();
        glb_we = 1'b0;
        chk("R9 accept beats write", glb_hi, 0);
        chk("R9 single-level keeps glb_lo", glb_lo, 1);
        pulse_ret();
        chk("R11 return sets glb_hi", glb_hi, 1);
        step(2);
        chk("R3 uncleared flag requests again", irq, 1);
        clr_flags('1);
        chk("R3 cleared no request", irq, 0);

        summary();
    end
endmodule